// File: doc/BRIEF.md
# Interrupt State Register Bank

This block stores the per-line interrupt state for 60 interrupt lines. For each line it keeps an enable flag, a pending flag, an active flag and a 4-bit priority. Software reaches the state over a simple word-addressed register bus. Every access completes in one cycle: a write is taken at the clock edge and read data follows the address combinationally.

The enable and pending bitmaps each have two write views. A set view turns on each bit written as 1. A clear view turns off each bit written as 1. Because of this, software can change a single line without reading the word first. Interrupt sources raise pending bits directly. Handler entry and exit strobes control the active bitmap, which software can only read.

The complete state is also driven out as flat vectors, so a downstream arbiter can use it.

Top module: `irq_state_bank`

## Requirements
- R1: After reset, every enable, pending, active and priority bit is 0. Every register address reads 0.
- R2: Words at addresses 0 and 1 are the enable-set view. Line n sits in word n>>5 at bit n&31. Writing 1 to a bit enables that line, and writing 0 leaves the line unchanged.
- R3: Words at addresses 8 and 9 are the enable-clear view, with the same layout as R2. Writing 1 to a bit disables that line, and writing 0 leaves the line unchanged.
- R4: Reading either the set view or the clear view of a bitmap word returns the current state of that word.
- R5: Pending has its own views with the same layout and the same write-one behaviour: set at addresses 16 and 17, clear at addresses 24 and 25.
- R6: A 1 on `hw_pend_set[n]` sets pending line n at the next edge. If a software pending-clear hits the same bit in the same cycle, the bit still ends up set.
- R7: Active words at addresses 32 and 33 are read-only. A bus write to them changes nothing. `hw_act_entry[n]` sets active line n and `hw_act_exit[n]` clears it. If both arrive in the same cycle, entry wins.
- R8: Priority words sit at addresses 64 to 78. Line n uses word 64+(n>>2), byte n&3. Only the upper 4 bits of each byte are stored. The lower 4 bits ignore writes and read 0.
- R9: Bit positions 60 to 63 of the bitmap words ignore writes and read 0. Any address not listed above reads 0, and a write to it changes no state.
- R10: `en_o`, `pend_o`, `act_o` and `prio_o` show the stored state and reflect a write from the edge that takes it. Line n's priority appears at `prio_o[4n+3:4n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| hw_pend_set | input | 60 | Per-line pending request from sources |
| hw_act_entry | input | 60 | Per-line handler entry strobe |
| hw_act_exit | input | 60 | Per-line handler exit strobe |
| en_o | output | 60 | Enable bitmap |
| pend_o | output | 60 | Pending bitmap |
| act_o | output | 60 | Active bitmap |
| prio_o | output | 240 | Priorities, 4 bits per line |

## Verification
Two pairs of functions can collide in one clock cycle. The first pair is a software pending-clear and a source raising the same pending bit. The second pair is a handler entry and a handler exit on the same line. The bench provokes the first by driving a clear-view write and `hw_pend_set` in the same low phase of the clock, on one shared bit and one unshared bit. It then reads the pending word back and expects the shared bit still set and the other bit cleared. The second collision is provoked the same way on the active strobes, and `act_o` is expected to keep the line set.

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int NUM_LINES = 60,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr_en,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_LINES-1:0]           hw_pend_set,
  input  logic [NUM_LINES-1:0]           hw_act_entry,
  input  logic [NUM_LINES-1:0]           hw_act_exit,
  output logic [NUM_LINES-1:0]           en_o,
  output logic [NUM_LINES-1:0]           pend_o,
  output logic [NUM_LINES-1:0]           act_o,
  output logic [NUM_LINES*PRIO_BITS-1:0] prio_o
);
  localparam int BM_WORDS   = (NUM_LINES + 31) / 32;
  localparam int BM_BITS    = BM_WORDS * 32;
  localparam int PRIO_WORDS = (NUM_LINES + 3) / 4;
  localparam int PRIO_LSB   = 8 - PRIO_BITS;
  localparam int A_EN_SET   = 0;
  localparam int A_EN_CLR   = 8;
  localparam int A_PD_SET   = 16;
  localparam int A_PD_CLR   = 24;
  localparam int A_ACT      = 32;
  localparam int A_PRIO     = 64;

  logic [NUM_LINES-1:0] en_q, pend_q, act_q;
  logic [PRIO_BITS-1:0] prio_q [NUM_LINES];
  logic [BM_BITS-1:0]   en_set_m, en_clr_m, pd_set_m, pd_clr_m;
  logic [BM_BITS-1:0]   en_pad, pend_pad, act_pad;

  always_comb begin
    en_set_m = '0;
    en_clr_m = '0;
    pd_set_m = '0;
    pd_clr_m = '0;
    for (int w = 0; w < BM_WORDS; w++) begin
      if (bus_wr_en && bus_addr == ADDR_W'(A_EN_SET + w)) en_set_m[w*32 +: 32] = bus_wdata;
      if (bus_wr_en && bus_addr == ADDR_W'(A_EN_CLR + w)) en_clr_m[w*32 +: 32] = bus_wdata;
      if (bus_wr_en && bus_addr == ADDR_W'(A_PD_SET + w)) pd_set_m[w*32 +: 32] = bus_wdata;
      if (bus_wr_en && bus_addr == ADDR_W'(A_PD_CLR + w)) pd_clr_m[w*32 +: 32] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      en_q   <= (en_q & ~en_clr_m[NUM_LINES-1:0]) | en_set_m[NUM_LINES-1:0];
      pend_q <= (pend_q & ~pd_clr_m[NUM_LINES-1:0]) | pd_set_m[NUM_LINES-1:0] | hw_pend_set;
      act_q  <= (act_q & ~hw_act_exit) | hw_act_entry;
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q[n] <= '0;
      else if (bus_wr_en && bus_addr == ADDR_W'(A_PRIO + n / 4))
        prio_q[n] <= bus_wdata[(n % 4) * 8 + PRIO_LSB +: PRIO_BITS];
    end
    assign prio_o[n*PRIO_BITS +: PRIO_BITS] = prio_q[n];
  end

  assign en_pad   = BM_BITS'(en_q);
  assign pend_pad = BM_BITS'(pend_q);
  assign act_pad  = BM_BITS'(act_q);

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < BM_WORDS; w++) begin
      if (bus_addr == ADDR_W'(A_EN_SET + w) || bus_addr == ADDR_W'(A_EN_CLR + w))
        bus_rdata = en_pad[w*32 +: 32];
      if (bus_addr == ADDR_W'(A_PD_SET + w) || bus_addr == ADDR_W'(A_PD_CLR + w))
        bus_rdata = pend_pad[w*32 +: 32];
      if (bus_addr == ADDR_W'(A_ACT + w))
        bus_rdata = act_pad[w*32 +: 32];
    end
    for (int k = 0; k < PRIO_WORDS; k++) begin
      if (bus_addr == ADDR_W'(A_PRIO + k)) begin
        for (int j = 0; j < 4; j++) begin
          if (k * 4 + j < NUM_LINES)
            bus_rdata[j*8 + PRIO_LSB +: PRIO_BITS] = prio_q[k*4 + j];
        end
      end
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk #(
  parameter int NUM_LINES = 60,
  parameter int ADDR_W    = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr_en,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] hw_pend_set,
  input logic [NUM_LINES-1:0] hw_act_entry,
  input logic [NUM_LINES-1:0] hw_act_exit,
  input logic [NUM_LINES-1:0] en_o,
  input logic [NUM_LINES-1:0] pend_o,
  input logic [NUM_LINES-1:0] act_o
);
  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == '0) |=> ((en_o[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(8)) |=> ((en_o[31:0] & $past(bus_wdata)) == '0));

  p_hw_pend_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_pend_set != '0) |=> ((pend_o & $past(hw_pend_set)) == $past(hw_pend_set)));

  p_act_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_act_entry != '0) |=> ((act_o & $past(hw_act_entry)) == $past(hw_act_entry)));

  p_act_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_act_exit & ~hw_act_entry) != '0) |=> ((act_o & $past(hw_act_exit & ~hw_act_entry)) == '0));

  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_en) |=> $stable(en_o));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(40) && bus_addr < ADDR_W'(64)) |-> (bus_rdata == '0));
endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_pend_set(hw_pend_set),
  .hw_act_entry(hw_act_entry), .hw_act_exit(hw_act_exit),
  .en_o(en_o), .pend_o(pend_o), .act_o(act_o)
);

// File: tb/sim_irq_state_bank.sv
module sim_irq_state_bank;
  localparam int N = 60;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          bus_wr_en = 0;
  logic [6:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  hw_pend_set = '0, hw_act_entry = '0, hw_act_exit = '0;
  logic [N-1:0]  en_o, pend_o, act_o;
  logic [N*4-1:0] prio_o;

  irq_state_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_pend_set(hw_pend_set),
    .hw_act_entry(hw_act_entry), .hw_act_exit(hw_act_exit),
    .en_o(en_o), .pend_o(pend_o), .act_o(act_o), .prio_o(prio_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [6:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t     sb[$];
  int           checks = 0;
  int           errors = 0;
  logic         rd_vld = 0;
  logic         done = 0;
  logic [N-1:0] m_en = '0, m_pend = '0, m_act = '0;
  logic [3:0]   m_prio [N];

  function automatic logic [31:0] exp_word(input logic [6:0] a);
    logic [63:0] e, p, t;
    logic [31:0] r;
    e = 64'(m_en); p = 64'(m_pend); t = 64'(m_act);
    r = '0;
    if (a == 0 || a == 8)  r = e[31:0];
    if (a == 1 || a == 9)  r = e[63:32];
    if (a == 16 || a == 24) r = p[31:0];
    if (a == 17 || a == 25) r = p[63:32];
    if (a == 32) r = t[31:0];
    if (a == 33) r = t[63:32];
    if (a >= 64 && a <= 78)
      for (int j = 0; j < 4; j++) r[j*8+4 +: 4] = m_prio[(int'(a) - 64) * 4 + j];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    logic [63:0] m;
    @(negedge clk);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 0;
    m = '0;
    if (a[0]) m[63:32] = d; else m[31:0] = d;
    if (a == 0 || a == 1) m_en = m_en | m[N-1:0];
    if (a == 8 || a == 9) m_en = m_en & ~m[N-1:0];
    if (a == 16 || a == 17) m_pend = m_pend | m[N-1:0];
    if (a == 24 || a == 25) m_pend = m_pend & ~m[N-1:0];
    if (a >= 64 && a <= 78)
      for (int j = 0; j < 4; j++) m_prio[(int'(a) - 64) * 4 + j] = d[j*8+4 +: 4];
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_wr_en = 0; bus_addr = a;
    it.addr = a; it.exp = exp_word(a); it.tag = tag;
    sb.push_back(it);
    rd_vld = 1;
    @(negedge clk);
    rd_vld = 0;
  endtask

  task automatic hw(input logic [N-1:0] ps, input logic [N-1:0] ae, input logic [N-1:0] ax);
    @(negedge clk);
    hw_pend_set = ps; hw_act_entry = ae; hw_act_exit = ax;
    @(negedge clk);
    hw_pend_set = '0; hw_act_entry = '0; hw_act_exit = '0;
    m_pend = m_pend | ps;
    m_act = (m_act & ~ax) | ae;
  endtask

  task automatic chk_all(input string tag);
    logic [N*4-1:0] pe;
    for (int n = 0; n < N; n++) pe[n*4 +: 4] = m_prio[n];
    chk({tag, " en_o"}, 256'(en_o), 256'(m_en));
    chk({tag, " pend_o"}, 256'(pend_o), 256'(m_pend));
    chk({tag, " act_o"}, 256'(act_o), 256'(m_act));
    chk({tag, " prio_o"}, 256'(prio_o), 256'(pe));
  endtask

  initial begin
    forever begin
      rd_item_t it;
      @(posedge clk);
      #2;
      if (rd_vld && sb.size() > 0) begin
        it = sb.pop_front();
        chk({it.tag, " rdata"}, 256'(bus_rdata), 256'(it.exp));
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < N; n++) m_prio[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1 reset");
    rd(0, "R1 en word0");
    rd(16, "R1 pend word0");
    rd(32, "R1 act word0");
    rd(64, "R1 prio word0");

    wr(0, 32'h8000_0011);
    chk_all("R10 after enable set");
    rd(0, "R2 set view");
    rd(8, "R4 clear view mirrors state");
    wr(1, 32'hFFFF_FFFF);
    rd(1, "R9 unused top bits read 0");
    rd(9, "R4 clear view word1");
    wr(0, 32'h0);
    rd(0, "R2 write zero no effect");
    wr(8, 32'h0000_0011);
    rd(0, "R3 clear bits 0 and 4");
    wr(9, 32'h0000_0001);
    rd(1, "R3 clear bit 32");
    chk_all("R3 outputs");

    wr(16, 32'h0000_00A5);
    wr(17, 32'h0000_0001);
    wr(24, 32'h0000_0005);
    rd(16, "R5 pending set then clear");
    rd(25, "R5 pending clear view reads state");

    hw(60'(1) << 40, '0, '0);
    rd(17, "R6 source sets pending");

    @(negedge clk);
    bus_wr_en = 1; bus_addr = 24; bus_wdata = 32'h0000_00A0;
    hw_pend_set = 60'(1) << 5;
    @(negedge clk);
    bus_wr_en = 0; hw_pend_set = '0;
    m_pend[7] = 1'b0;
    rd(16, "R6 source set beats software clear");
    chk_all("R6 outputs");

    wr(32, 32'hFFFF_FFFF);
    wr(33, 32'hFFFF_FFFF);
    rd(32, "R7 active write ignored");
    hw('0, (60'(1) << 3) | (60'(1) << 33), '0);
    rd(33, "R7 entry sets active");
    hw('0, 60'(1) << 3, (60'(1) << 3) | (60'(1) << 33));
    chk_all("R7 entry beats exit, exit clears");
    rd(32, "R7 active word0");

    wr(64, 32'hFFFF_FFFF);
    rd(64, "R8 low nibbles read 0");
    wr(78, 32'h1234_5678);
    rd(78, "R8 last priority word");
    chk("R8 line 59 prio", 256'(prio_o[59*4 +: 4]), 256'(4'h1));
    chk("R8 line 56 prio", 256'(prio_o[56*4 +: 4]), 256'(4'h7));

    wr(79, 32'hFFFF_FFFF);
    wr(40, 32'hFFFF_FFFF);
    chk_all("R9 unmapped write no effect");
    rd(79, "R9 unmapped read 0");
    rd(127, "R9 unmapped read 0 high");
    rd(40, "R9 unmapped read 0 mid");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule